// File: doc/BRIEF.md
# Key Event Queue With Count and Interrupt

This block holds the press and release events produced by a keypad scanner until a host collects them. The scanner offers one event at a time: a press/release flag and a key code. The block packs them into an 8-bit word and appends that word to a ten-slot first-in first-out queue. The host sees the oldest word on a head port at all times. A read strobe consumes that word, and every remaining word moves one slot toward the head.

The block keeps a 4-bit count of the stored words. An event flag is raised whenever an event is accepted, and an active-low interrupt line follows that flag. The host clears the flag by writing 1 to it, but the clear has effect only once the queue is empty. If the queue is full, a further event is discarded and a sticky overflow flag records the loss. The overflow flag is cleared by writing 1 to it.

The host bus is reduced to single-cycle strobes: one for reading the head, one for each write-1-to-clear flag. Matrix scanning and debouncing happen upstream.

Top module: `keyev_queue`

## Requirements
- R1: The queue stores at most DEPTH (default 10) words, and `count_o` never exceeds DEPTH.
- R2: An accepted event stores the word {press_i, code_i}: bit 7 is 1 for a press and 0 for a release, and bits 6:0 are the key code (0 to 80 for matrix keys, 97 to 114 for general-purpose inputs). `count_o` rises by one on the following edge.
- R3: `head_o` always shows the oldest stored word. A read strobe while the count is non-zero lowers the count by one and moves every remaining word one slot toward the head. Events pushed on consecutive cycles, such as several keys pressed at once, come out in arrival order.
- R4: When the count is zero, `head_o` is 0x00, and a read strobe leaves the count at zero.
- R5: A push and a read in the same cycle on a non-empty queue leave the count unchanged. The new word lands directly behind the shifted words.
- R6: A push while the queue holds DEPTH words and no read is strobed is dropped. The count stays at DEPTH, the contents are unchanged and `ovf_flag_o` is set. A push together with a read on a full queue is accepted.
- R7: `ovf_flag_o` stays set until a write of 1 on `ovf_clr_i`, which clears it on the next edge unless a new drop happens in the same cycle.
- R8: `evt_flag_o` is set on the edge at which an event is accepted.
- R9: A write of 1 on `evt_clr_i` clears `evt_flag_o` only when the count is zero and no event is accepted in that cycle. Otherwise it has no effect, so the flag stays set while any word remains.
- R10: `int_n_o` is always the inverse of `evt_flag_o`.
- R11: After reset the count is 0, `head_o` is 0x00, both flags are 0 and `int_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Event offered by the scanner this cycle |
| press_i | input | 1 | 1 for a press, 0 for a release |
| code_i | input | 7 | Key code of the offered event |
| rd_i | input | 1 | Host read strobe for the head word |
| evt_clr_i | input | 1 | Write-1 clear of the event flag |
| ovf_clr_i | input | 1 | Write-1 clear of the overflow flag |
| head_o | output | 8 | Oldest stored word, 0x00 when empty |
| count_o | output | 4 | Number of stored words |
| evt_flag_o | output | 1 | Event interrupt flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| int_n_o | output | 1 | Active-low interrupt |

## Verification
The count, both flags and the interrupt line change one clock edge after the strobe that affects them. `head_o` is a register output, so the word a read consumes is the value shown during the cycle of the strobe, and the next word appears after that edge. The bench drives strobes on the falling edge and compares every output on the next falling edge against a queue model updated for the edge in between. The head is therefore compared in the very cycle it is consumed, and the count and flags exactly one edge after their cause.

// File: rtl/keyev_pkg.sv
package keyev_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_PUSH = 2'b01,
      OP_POP  = 2'b10,
      OP_BOTH = 2'b11
   } keyev_op_e;
endpackage

// File: rtl/keyev_ctrl.sv
module keyev_ctrl #(
   parameter int DEPTH = 10,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             rd_i,
   output logic             accept_o,
   output logic             rd_eff_o,
   output logic             drop_o,
   output logic [CNT_W-1:0] wr_idx_o,
   output logic [CNT_W-1:0] count_o
);
   import keyev_pkg::*;

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count_q;
   logic             full;
   logic             empty;
   keyev_op_e        op;

   assign full     = (count_q == FULL_CNT);
   assign empty    = (count_q == '0);
   assign rd_eff_o = rd_i && !empty;
   assign accept_o = push_i && (!full || rd_eff_o);
   assign drop_o   = push_i && !accept_o;
   assign wr_idx_o = count_q - CNT_W'(rd_eff_o);
   assign op       = keyev_op_e'({rd_eff_o, accept_o});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         unique case (op)
            OP_PUSH: count_q <= count_q + CNT_W'(1);
            OP_POP:  count_q <= count_q - CNT_W'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   assign count_o = count_q;
endmodule

// File: rtl/keyev_slots.sv
module keyev_slots #(
   parameter int DEPTH = 10,
   parameter int WORD_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              rd_eff_i,
   input  logic [CNT_W-1:0]  wr_idx_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] head_o
);
   logic [WORD_W-1:0] slot_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [WORD_W-1:0] above;
      logic [WORD_W-1:0] shifted;
      logic              hit;

      if (i == DEPTH - 1) begin : g_top
         assign above = '0;
      end else begin : g_mid
         assign above = slot_q[i+1];
      end

      assign shifted = rd_eff_i ? above : slot_q[i];
      assign hit     = accept_i && (wr_idx_i == CNT_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[i] <= '0;
         end else begin
            slot_q[i] <= hit ? word_i : shifted;
         end
      end
   end

   assign head_o = slot_q[0];
endmodule

// File: rtl/keyev_flags.sv
module keyev_flags #(
   parameter int DEPTH = 10,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             drop_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             evt_clr_i,
   input  logic             ovf_clr_i,
   output logic             evt_flag_o,
   output logic             ovf_flag_o,
   output logic             int_n_o
);
   logic evt_q;
   logic ovf_q;
   logic evt_clr_ok;

   assign evt_clr_ok = evt_clr_i && (count_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (accept_i) begin
            evt_q <= 1'b1;
         end else if (evt_clr_ok) begin
            evt_q <= 1'b0;
         end
         if (drop_i) begin
            ovf_q <= 1'b1;
         end else if (ovf_clr_i) begin
            ovf_q <= 1'b0;
         end
      end
   end

   assign evt_flag_o = evt_q;
   assign ovf_flag_o = ovf_q;
   assign int_n_o    = ~evt_q;
endmodule

// File: rtl/keyev_queue.sv
module keyev_queue #(
   parameter int DEPTH = 10,
   parameter int CODE_W = 7,
   localparam int WORD_W = CODE_W + 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              press_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              rd_i,
   input  logic              evt_clr_i,
   input  logic              ovf_clr_i,
   output logic [WORD_W-1:0] head_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              evt_flag_o,
   output logic              ovf_flag_o,
   output logic              int_n_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("keyev_queue: DEPTH must be at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("keyev_queue: CODE_W must be at least 1");
   end

   logic             accept;
   logic             rd_eff;
   logic             drop;
   logic [CNT_W-1:0] wr_idx;
   logic [CNT_W-1:0] count;

   keyev_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (push_i),
      .rd_i     (rd_i),
      .accept_o (accept),
      .rd_eff_o (rd_eff),
      .drop_o   (drop),
      .wr_idx_o (wr_idx),
      .count_o  (count)
   );

   keyev_slots #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .rd_eff_i (rd_eff),
      .wr_idx_i (wr_idx),
      .word_i   ({press_i, code_i}),
      .head_o   (head_o)
   );

   keyev_flags #(.DEPTH(DEPTH)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .drop_i     (drop),
      .count_i    (count),
      .evt_clr_i  (evt_clr_i),
      .ovf_clr_i  (ovf_clr_i),
      .evt_flag_o (evt_flag_o),
      .ovf_flag_o (ovf_flag_o),
      .int_n_o    (int_n_o)
   );

   assign count_o = count;
endmodule

// File: rtl/keyev_queue_chk.sv
module keyev_queue_chk #(
   parameter int DEPTH = 10,
   parameter int WORD_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic              rd_i,
   input logic              evt_clr_i,
   input logic [WORD_W-1:0] head_o,
   input logic [CNT_W-1:0]  count_o,
   input logic              evt_flag_o,
   input logic              ovf_flag_o,
   input logic              int_n_o
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   p_count_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= FULL_CNT);

   p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !rd_i && count_o != FULL_CNT) |=> count_o == $past(count_o) + CNT_W'(1));

   p_pop_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !push_i && count_o != '0) |=> count_o == $past(count_o) - CNT_W'(1));

   p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count_o == '0 |-> head_o == '0);

   p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && push_i && count_o != '0) |=> $stable(count_o));

   p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !rd_i && count_o == FULL_CNT) |=> (ovf_flag_o && count_o == FULL_CNT));

   p_accept_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && count_o != FULL_CNT) |=> evt_flag_o);

   p_flag_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count_o != '0 |-> evt_flag_o);

   p_clr_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr_i && evt_flag_o && count_o != '0) |=> evt_flag_o);

   p_pin_inverse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int_n_o == !evt_flag_o);
endmodule

bind keyev_queue keyev_queue_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_i     (push_i),
   .rd_i       (rd_i),
   .evt_clr_i  (evt_clr_i),
   .head_o     (head_o),
   .count_o    (count_o),
   .evt_flag_o (evt_flag_o),
   .ovf_flag_o (ovf_flag_o),
   .int_n_o    (int_n_o)
);

// File: tb/sim_keyev_queue.sv
`timescale 1ns/1ps
module sim_keyev_queue;
   localparam int DEPTH = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0;
   logic       press_i = 1'b0;
   logic [6:0] code_i = '0;
   logic       rd_i = 1'b0;
   logic       evt_clr_i = 1'b0;
   logic       ovf_clr_i = 1'b0;
   logic [7:0] head_o;
   logic [3:0] count_o;
   logic       evt_flag_o;
   logic       ovf_flag_o;
   logic       int_n_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] mq[$];
   bit m_evt = 1'b0;
   bit m_ovf = 1'b0;

   always #4 clk = ~clk;

   keyev_queue u0 (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .press_i(press_i), .code_i(code_i),
      .rd_i(rd_i), .evt_clr_i(evt_clr_i), .ovf_clr_i(ovf_clr_i), .head_o(head_o),
      .count_o(count_o), .evt_flag_o(evt_flag_o), .ovf_flag_o(ovf_flag_o), .int_n_o(int_n_o)
   );

   function automatic logic [7:0] exp_head();
      return (mq.size() > 0) ? mq[0] : 8'h00;
   endfunction

   function automatic logic [6:0] pick_code();
      int r = int'($urandom_range(0, 98));
      return (r <= 80) ? 7'(r) : 7'(97 + (r - 81));
   endfunction

   task automatic cmp(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Compare all outputs to the model, then drive one cycle of stimulus
   task automatic cyc(bit push, bit press, logic [6:0] code, bit rd, bit eclr, bit oclr);
      bit rd_eff, acc;
      int sz;
      cmp("R3 head", int'(head_o), int'(exp_head()));
      cmp("R2 count", int'(count_o), mq.size());
      cmp("R9 evt_flag", int'(evt_flag_o), int'(m_evt));
      cmp("R7 ovf_flag", int'(ovf_flag_o), int'(m_ovf));
      cmp("R10 int_n", int'(int_n_o), int'(!m_evt));
      push_i = push; press_i = press; code_i = code; rd_i = rd;
      evt_clr_i = eclr; ovf_clr_i = oclr;
      sz = mq.size();
      rd_eff = rd && (sz > 0);
      acc = push && ((sz < DEPTH) || rd_eff);
      if (rd_eff) void'(mq.pop_front());
      if (acc) mq.push_back({press, code});
      if (acc) m_evt = 1'b1;
      else if (eclr && sz == 0) m_evt = 1'b0;
      if (push && !acc) m_ovf = 1'b1;
      else if (oclr) m_ovf = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      // R11: reset state
      cmp("R11 count", int'(count_o), 0);
      cmp("R11 head", int'(head_o), 0);
      cmp("R11 flags", int'({evt_flag_o, ovf_flag_o}), 0);
      cmp("R11 int_n", int'(int_n_o), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: empty read yields zero and keeps count zero
      cyc(0, 0, 0, 1, 0, 0);
      cmp("R4 empty count", int'(count_o), 0);
      cmp("R4 empty head", int'(head_o), 0);

      // R3/R2: three simultaneous key presses stored in order
      cyc(1, 1, 7'd5, 0, 0, 0);
      cyc(1, 1, 7'd6, 0, 0, 0);
      cyc(1, 1, 7'd80, 0, 0, 0);
      cmp("R8 flag after push", int'(evt_flag_o), 1);
      // R9: clear ignored while events remain
      cyc(0, 0, 0, 0, 1, 0);
      cmp("R9 clear blocked", int'(evt_flag_o), 1);
      // R5: push and read together
      cyc(1, 0, 7'd5, 1, 0, 0);
      cmp("R5 count held", int'(count_o), 3);
      // R1/R6: fill to full then overflow
      for (int i = 0; i < 9; i++) cyc(1, i[0], 7'(97 + i), 0, 0, 0);
      cmp("R1 full count", int'(count_o), DEPTH);
      cmp("R6 overflow set", int'(ovf_flag_o), 1);
      // R6: push plus read on full is accepted
      cyc(1, 1, 7'd114, 1, 0, 0);
      cmp("R6 full both", int'(count_o), DEPTH);
      // R7: overflow clear
      cyc(0, 0, 0, 0, 0, 1);
      cmp("R7 overflow cleared", int'(ovf_flag_o), 0);
      // R3: drain, then R4 read past empty
      for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 1, 0, 0);
      cmp("R4 drained head", int'(head_o), 0);
      // R9: clear works when empty
      cyc(0, 0, 0, 0, 1, 0);
      cmp("R9 clear when empty", int'(evt_flag_o), 0);
      cmp("R10 pin released", int'(int_n_o), 1);

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         bit p = ($urandom_range(0, 99) < 55);
         bit r = ($urandom_range(0, 99) < 45);
         bit ec = ($urandom_range(0, 99) < 10);
         bit oc = ($urandom_range(0, 99) < 5);
         cyc(p, 1'($urandom_range(0, 1)), pick_code(), r, ec, oc);
      end
      cyc(0, 0, 0, 0, 0, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule